// File: doc/BRIEF.md
# CRB Control Register File

This block is the register-side half of a command-response-buffer interface for a trusted-module controller. Software reaches it through a 4 KiB memory-mapped window. The window holds the locality handshake words, a fixed 64-bit identification word and the idle handshake. It also holds a start flag, the command and response size and address words, and a 3968-byte message buffer that begins at byte 0x80. Every request on the slave port gets a response one cycle later. That response carries read data or an error flag.

Most writable words trigger side effects rather than plain storage. A locality write grants or releases the locality. A request write moves the idle flag. A start write raises a one-cycle pulse towards the execution engine and holds a busy flag. The engine clears that flag by asserting `engine_done` when it has finished. Each offset carries its own write permission, and read-only or reserved words reject writes with an error.

Top module: `crb_regfile`

## Requirements
- R1: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the next cycle, and `rsp_valid` is low in every other cycle.
- R2: A request is answered with `rsp_err`=1 and leaves all state unchanged if its address is not a multiple of its byte count, or if the address is 0x1000 or higher. An error response carries `rsp_rdata`=0. `req_size` encodes 0,1,2,3 as 1,2,4,8 bytes.
- R3: A read returns the addressed bytes little-endian and right-aligned in `rsp_rdata`, with zeros above the access size. Reserved locations read as zero. The cancel word (0x48) and the request word (0x40) always read as zero.
- R4: After reset, the following hold: 0x00 reads 0x81 (bit 0 established, bit 7 request-valid), 0x44 reads 0x2 (bit 1 idle), the words at 0x58 and 0x64 read 0xF80, the command address at 0x5C/0x60 and the response address at 0x68 hold window base + 0x80, and `start_busy`=0.
- R5: The 8-byte word at 0x30 reads 0x1014_1014_0002_5811: type 1, version 1, transfer-size capability 3 at bits 12:11, CRB capability bit 14 set, FIFO and locality capabilities clear, selector 1 at bits 18:17, vendor id and device id 0x1014.
- R6: A write to 0x08 with bit 1 (release) set clears both the granted flag (0x0C bit 0) and the assigned flag (0x00 bit 1). Otherwise, bit 0 (request) set sets both flags. Release wins when both bits are set.
- R7: A write to 0x40 with bit 0 (ready) set and bit 1 (go idle) clear clears the idle flag (0x44 bit 1). Bit 0 clear with bit 1 set sets the flag. Any other combination leaves it unchanged.
- R8: A write to 0x4C with bit 0 set while start is clear sets start (0x4C bit 0 and `start_busy`) and pulses `start_pulse` for one cycle, both visible on the cycle after the write. A write with bit 0 clear, or a write while start is set, has no effect.
- R9: `engine_done` clears start on the next cycle and overrides a start write in the same cycle, which then produces no pulse.
- R10: Writes succeed only in three regions: 0x58–0x6F (stored bytes, any size), 0x80–0xFFF (the buffer), and the words 0x08, 0x40, 0x48, 0x4C (sizes up to 4 bytes). An 8-byte write to those four words, and any write elsewhere, returns an error and changes nothing.
- R11: Writes narrower than 32 bits to 0x08, 0x40 and 0x4C are placed at bit 8 × (address mod 4) before decoding. For example, a one-byte write of 1 at 0x4D does not set start.
- R12: Writes to 0x48 are accepted without error and have no effect.
- R13: The buffer stores individual bytes written at any legal size and alignment, and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte offset within the window |
| req_size | input | 2 | Log2 of the access byte count |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data, right-aligned |
| engine_done | input | 1 | Engine finished; clears start |
| start_busy | output | 1 | Start flag |
| start_pulse | output | 1 | One-cycle command launch |

## Verification
Every result of a request is due on the single clock edge that follows it: the response, the error flag, the start flag and the start pulse. A read that follows a write therefore observes the write's side effect. The bench drives each request on a falling edge and updates a behavioural model of the window. On the next falling edge it compares `rsp_valid`, `rsp_err`, `rsp_rdata`, `start_busy` and `start_pulse` against the model, so every output is compared on every cycle. The same-cycle collision of `engine_done` with a start write is driven explicitly.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int WIN_BITS   = 12;
    localparam int WORD_BYTES = 8;
    localparam int BUF_BASE   = 'h80;
    localparam int BUF_BYTES  = 'hF80;
    localparam int BUF_WORDS  = BUF_BYTES / WORD_BYTES;

    localparam logic [11:0] OFF_LOC_CTL = 12'h008;
    localparam logic [11:0] OFF_REQ     = 12'h040;
    localparam logic [11:0] OFF_CANCEL  = 12'h048;
    localparam logic [11:0] OFF_START   = 12'h04C;
    localparam logic [11:0] OFF_STORE_L = 12'h058;
    localparam logic [11:0] OFF_STORE_H = 12'h06C;

    typedef enum logic [1:0] {SZ_1 = 2'd0, SZ_2 = 2'd1, SZ_4 = 2'd2, SZ_8 = 2'd3} acc_size_e;

    typedef struct packed {
        logic err;
        logic rd;
        logic buf_sel;
        logic wr_locctl;
        logic wr_req;
        logic wr_cancel;
        logic wr_start;
        logic wr_store;
        logic wr_buf;
    } dec_t;
endpackage

// File: rtl/crb_decode.sv
module crb_decode
    import crb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output dec_t              dec,
    output logic [63:0]       wdata_lane,
    output logic [7:0]        byte_en,
    output logic [31:0]       ctl_lane
);
    logic [2:0]  align_mask;
    logic        misaligned;
    logic        outside;
    logic [11:0] off;
    logic [11:0] reg32;
    logic [63:0] data_mask;
    logic [7:0]  be_base;
    logic        narrow;

    always_comb begin
        align_mask = 3'(((4'd1 << req_size) - 4'd1));
        misaligned = |(req_addr[2:0] & align_mask);
        outside    = |req_addr[ADDR_W-1:WIN_BITS];
        off        = req_addr[11:0];
        reg32      = {off[11:2], 2'b00};
        narrow     = (req_size != SZ_8);
        case (req_size)
            SZ_1:    begin data_mask = 64'hFF;        be_base = 8'h01; end
            SZ_2:    begin data_mask = 64'hFFFF;      be_base = 8'h03; end
            SZ_4:    begin data_mask = 64'hFFFF_FFFF; be_base = 8'h0F; end
            default: begin data_mask = '1;            be_base = 8'hFF; end
        endcase
        wdata_lane = (req_wdata & data_mask) << {req_addr[2:0], 3'b000};
        byte_en    = be_base << req_addr[2:0];
        ctl_lane   = req_addr[2] ? wdata_lane[63:32] : wdata_lane[31:0];

        dec = '0;
        if (req_valid) begin
            if (misaligned || outside) begin
                dec.err = 1'b1;
            end else if (!req_write) begin
                dec.rd      = 1'b1;
                dec.buf_sel = (off >= 12'(BUF_BASE));
            end else if (off >= 12'(BUF_BASE)) begin
                dec.wr_buf = 1'b1;
            end else if (reg32 >= OFF_STORE_L && reg32 <= OFF_STORE_H) begin
                dec.wr_store = 1'b1;
            end else if (reg32 == OFF_LOC_CTL) begin
                dec.wr_locctl = narrow;
                dec.err       = !narrow;
            end else if (reg32 == OFF_REQ) begin
                dec.wr_req = narrow;
                dec.err    = !narrow;
            end else if (reg32 == OFF_CANCEL) begin
                dec.wr_cancel = narrow;
                dec.err       = !narrow;
            end else if (reg32 == OFF_START) begin
                dec.wr_start = narrow;
                dec.err      = !narrow;
            end else begin
                dec.err = 1'b1;
            end
        end
    end
endmodule

// File: rtl/crb_ctrl_regs.sv
module crb_ctrl_regs
    import crb_pkg::*;
#(
    parameter logic [63:0] WIN_BASE = 64'h0000_0000_FED4_0000,
    parameter logic [3:0]  ID_TYPE  = 4'h1,
    parameter logic [3:0]  ID_VER   = 4'h1,
    parameter logic [1:0]  ID_XFER  = 2'd3,
    parameter logic [1:0]  ID_SEL   = 2'd1,
    parameter logic [15:0] ID_VEND  = 16'h1014,
    parameter logic [15:0] ID_DEV   = 16'h1014
) (
    input  logic        clk,
    input  logic        rst_n,
    input  dec_t        dec,
    input  logic [31:0] ctl_lane,
    input  logic [63:0] wdata_lane,
    input  logic [7:0]  byte_en,
    input  logic [3:0]  word_idx,
    input  logic        engine_done,
    output logic [63:0] rd_word,
    output logic        start_busy,
    output logic        start_pulse
);
    localparam logic [63:0] BUF_ADDR = WIN_BASE + 64'(BUF_BASE);
    localparam logic [31:0] BUF_SZ   = 32'(BUF_BYTES);
    localparam logic [63:0] ID_WORD  = {ID_DEV, ID_VEND, 8'h00, 4'h0, 1'b0, ID_SEL,
                                        2'b00, 1'b1, 1'b0, ID_XFER, 1'b0, 1'b0, 1'b0,
                                        ID_VER, ID_TYPE};

    typedef struct packed {
        logic            assigned;
        logic            idle;
        logic            start;
        logic            pulse;
        logic [2:0][63:0] store;
    } ctl_t;

    ctl_t s_q, s_d;
    logic [1:0] slot;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        slot      = 2'(word_idx - 4'd11);
        if (dec.wr_locctl) begin
            if (ctl_lane[1])      s_d.assigned = 1'b0;
            else if (ctl_lane[0]) s_d.assigned = 1'b1;
        end
        if (dec.wr_req) begin
            if (ctl_lane[0] && !ctl_lane[1])      s_d.idle = 1'b0;
            else if (!ctl_lane[0] && ctl_lane[1]) s_d.idle = 1'b1;
        end
        if (dec.wr_start && ctl_lane[0] && !s_q.start && !engine_done) begin
            s_d.start = 1'b1;
            s_d.pulse = 1'b1;
        end
        if (engine_done) s_d.start = 1'b0;
        if (dec.wr_store) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
                if (byte_en[b]) s_d.store[slot][8*b +: 8] = wdata_lane[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.assigned <= 1'b0;
            s_q.idle     <= 1'b1;
            s_q.start    <= 1'b0;
            s_q.pulse    <= 1'b0;
            s_q.store[0] <= {BUF_ADDR[31:0], BUF_SZ};
            s_q.store[1] <= {BUF_SZ, BUF_ADDR[63:32]};
            s_q.store[2] <= BUF_ADDR;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (word_idx)
            4'd0:    rd_word = {56'b0, 1'b1, 2'b00, 3'b000, s_q.assigned, 1'b1};
            4'd1:    rd_word = {31'b0, s_q.assigned, 32'b0};
            4'd6:    rd_word = ID_WORD;
            4'd8:    rd_word = {30'b0, s_q.idle, 1'b0, 32'b0};
            4'd9:    rd_word = {31'b0, s_q.start, 32'b0};
            4'd11:   rd_word = s_q.store[0];
            4'd12:   rd_word = s_q.store[1];
            4'd13:   rd_word = s_q.store[2];
            default: rd_word = '0;
        endcase
    end

    assign start_busy  = s_q.start;
    assign start_pulse = s_q.pulse;

    assert_relinquish_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_locctl && ctl_lane[1]) |=> !s_q.assigned);
    assert_ready_clears_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.wr_req && ctl_lane[0] && !ctl_lane[1]) |=> !s_q.idle);
    assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (start_busy && !$past(start_busy)));
    assert_done_clears_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        engine_done |=> !start_busy);
endmodule

// File: rtl/crb_data_buf.sv
module crb_data_buf
    import crb_pkg::*;
#(
    parameter int DEPTH = BUF_WORDS,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       byte_en,
    input  logic [63:0]      wdata,
    output logic [63:0]      rdata
);
    logic [63:0] mem [DEPTH];
    logic [63:0] rdata_q;

    always_ff @(posedge clk) begin
        for (int b = 0; b < WORD_BYTES; b++) begin
            if (wr_en && byte_en[b] && (32'(idx) < DEPTH)) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
        end
        if (rd_en && (32'(idx) < DEPTH)) rdata_q <= mem[idx];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile
    import crb_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [63:0] WIN_BASE = 64'h0000_0000_FED4_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    input  logic              engine_done,
    output logic              start_busy,
    output logic              start_pulse
);
    localparam int IDX_W = $clog2(BUF_WORDS);

    typedef struct packed {
        logic        valid;
        logic        err;
        logic        buf_sel;
        logic [2:0]  shift;
        logic [1:0]  size;
        logic [63:0] ctl_word;
    } rsp_t;

    dec_t        dec;
    logic [63:0] wdata_lane;
    logic [7:0]  byte_en;
    logic [31:0] ctl_lane;
    logic [63:0] ctl_word;
    logic [63:0] buf_word;
    logic [IDX_W-1:0] buf_idx;
    rsp_t r_q, r_d;
    logic [63:0] sel_word;
    logic [63:0] shifted;

    crb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .dec       (dec),
        .wdata_lane(wdata_lane),
        .byte_en   (byte_en),
        .ctl_lane  (ctl_lane)
    );

    crb_ctrl_regs #(.WIN_BASE(WIN_BASE)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .ctl_lane   (ctl_lane),
        .wdata_lane (wdata_lane),
        .byte_en    (byte_en),
        .word_idx   (req_addr[6:3]),
        .engine_done(engine_done),
        .rd_word    (ctl_word),
        .start_busy (start_busy),
        .start_pulse(start_pulse)
    );

    assign buf_idx = IDX_W'(req_addr[WIN_BITS-1:3] - 9'(BUF_BASE / WORD_BYTES));

    crb_data_buf #(.DEPTH(BUF_WORDS)) u_buf (
        .clk    (clk),
        .wr_en  (dec.wr_buf),
        .rd_en  (dec.rd && dec.buf_sel),
        .idx    (buf_idx),
        .byte_en(byte_en),
        .wdata  (wdata_lane),
        .rdata  (buf_word)
    );

    always_comb begin
        r_d          = '0;
        r_d.valid    = req_valid;
        r_d.err      = dec.err;
        r_d.buf_sel  = dec.rd && dec.buf_sel;
        r_d.shift    = req_addr[2:0];
        r_d.size     = req_size;
        r_d.ctl_word = (dec.rd && !dec.buf_sel) ? ctl_word : 64'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        sel_word = r_q.buf_sel ? buf_word : r_q.ctl_word;
        shifted  = sel_word >> {r_q.shift, 3'b000};
        case (r_q.size)
            SZ_1:    rsp_rdata = {56'b0, shifted[7:0]};
            SZ_2:    rsp_rdata = {48'b0, shifted[15:0]};
            SZ_4:    rsp_rdata = {32'b0, shifted[31:0]};
            default: rsp_rdata = shifted;
        endcase
        if (r_q.err || !r_q.valid) rsp_rdata = '0;
    end

    assign rsp_valid = r_q.valid;
    assign rsp_err   = r_q.err;

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_misaligned_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_addr[2:0] & 3'((4'd1 << req_size) - 4'd1)) != 3'b0)) |=> rsp_err);
    assert_err_data_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'b0));
endmodule

// File: tb/tb_crb_regfile.sv
module tb_crb_regfile;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE80 = 64'h0000_0000_FED4_0080;
    localparam logic [63:0] IDW = 64'h1014_1014_0002_5811;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, engine_done = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [63:0] req_wdata = '0;
    logic rsp_valid, rsp_err, start_busy, start_pulse;
    logic [63:0] rsp_rdata;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    bit m_assigned, m_idle, m_start;
    logic [7:0] m_store [0:23];
    logic [7:0] m_buf [int];
    logic [63:0] e_rd;
    bit e_valid, e_err, e_pulse;
    logic [63:0] lcg = 64'h1234_5678_9ABC_DEF1;

    always #(CLK_PERIOD/2) clk = ~clk;

    crb_regfile dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .engine_done(engine_done), .start_busy(start_busy), .start_pulse(start_pulse)
    );

    function automatic logic [7:0] mbyte(int a);
        if (a >= 'h80) return m_buf.exists(a) ? m_buf[a] : 8'h00;
        if (a >= 'h58 && a < 'h70) return m_store[a - 'h58];
        if (a == 'h00) return 8'h81 | (8'(m_assigned) << 1);
        if (a == 'h0C) return 8'(m_assigned);
        if (a >= 'h30 && a < 'h38) return IDW[8*(a-'h30) +: 8];
        if (a == 'h44) return 8'(m_idle) << 1;
        if (a == 'h4C) return 8'(m_start);
        return 8'h00;
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(bit v, bit w, int a, int sz, logic [63:0] wd, bit done, string req);
        int n = 1 << sz;
        bit set_start = 0;
        req_valid = v; req_write = w; req_addr = 16'(a); req_size = 2'(sz);
        req_wdata = wd; engine_done = done;
        e_valid = v; e_err = 0; e_rd = '0; e_pulse = 0;
        if (v) begin
            if ((a % n) != 0 || a >= 'h1000) begin
                e_err = 1;
            end else if (!w) begin
                for (int i = 0; i < n; i++) e_rd[8*i +: 8] = mbyte(a + i);
            end else begin
                int r32 = a & ~3;
                if (a >= 'h80) begin
                    for (int i = 0; i < n; i++) m_buf[a + i] = wd[8*i +: 8];
                end else if (r32 >= 'h58 && r32 <= 'h6C) begin
                    for (int i = 0; i < n; i++) m_store[a + i - 'h58] = wd[8*i +: 8];
                end else if (r32 == 'h08 || r32 == 'h40 || r32 == 'h48 || r32 == 'h4C) begin
                    if (n == 8) e_err = 1;
                    else begin
                        logic [63:0] msk = (n == 4) ? 64'hFFFF_FFFF : ((64'd1 << (8*n)) - 1);
                        logic [31:0] lane = 32'((wd & msk) << (8*(a % 4)));
                        if (r32 == 'h08) begin
                            if (lane[1]) m_assigned = 0;
                            else if (lane[0]) m_assigned = 1;
                        end else if (r32 == 'h40) begin
                            if (lane[0] && !lane[1]) m_idle = 0;
                            else if (!lane[0] && lane[1]) m_idle = 1;
                        end else if (r32 == 'h4C) begin
                            set_start = lane[0] && !m_start;
                        end
                    end
                end else e_err = 1;
            end
        end
        if (done) m_start = 0;
        else if (set_start) begin m_start = 1; e_pulse = 1; end
        @(negedge clk);
        check(req, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        if (e_valid) begin
            check(req, "rsp_err", 64'(rsp_err), 64'(e_err));
            check(req, "rsp_rdata", rsp_rdata, e_rd);
        end
        check(req, "start_busy", 64'(start_busy), 64'(m_start));
        check(req, "start_pulse", 64'(start_pulse), 64'(e_pulse));
    endtask

    task automatic rd(int a, int sz, string req); cyc(1, 0, a, sz, '0, 0, req); endtask
    task automatic wr(int a, int sz, logic [63:0] d, string req); cyc(1, 1, a, sz, d, 0, req); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_assigned = 0; m_idle = 1; m_start = 0;
        for (int i = 0; i < 4; i++) begin
            m_store[i]      = 8'((32'hF80) >> (8*i));
            m_store[4 + i]  = BASE80[8*i +: 8];
            m_store[8 + i]  = BASE80[32 + 8*i +: 8];
            m_store[12 + i] = 8'((32'hF80) >> (8*i));
        end
        for (int i = 0; i < 8; i++) m_store[16 + i] = BASE80[8*i +: 8];
        repeat (3) @(negedge clk);
        check("R4", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        check("R4", "start_busy in reset", 64'(start_busy), 64'd0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, '0, 0, "R1");
        // R4 reset values
        rd('h00, 2, "R4"); rd('h44, 2, "R4"); rd('h58, 2, "R4"); rd('h5C, 2, "R4");
        rd('h60, 2, "R4"); rd('h64, 2, "R4"); rd('h68, 3, "R4"); rd('h4C, 2, "R4");
        // R5 identification
        rd('h30, 3, "R5"); rd('h34, 2, "R5"); rd('h31, 0, "R5");
        // R3 reserved and narrow reads
        rd('h10, 3, "R3"); rd('h50, 3, "R3"); rd('h40, 2, "R3"); rd('h59, 0, "R3"); rd('h5A, 1, "R3");
        // R2 errors
        rd('h02, 2, "R2"); rd('h6C, 3, "R2"); rd('h1000, 0, "R2"); wr('h5A, 2, 64'h1, "R2");
        wr('h2000, 2, 64'h1, "R2");
        // R10 write permission
        wr('h44, 2, 64'h0, "R10"); rd('h44, 2, "R10");
        wr('h30, 3, 64'h0, "R10"); rd('h30, 3, "R10");
        wr('h00, 2, 64'h2, "R10"); wr('h40, 3, 64'h1, "R10"); rd('h44, 2, "R10");
        wr('h48, 3, 64'h1_0000_0001, "R10"); rd('h4C, 2, "R10");
        wr('h70, 2, 64'h5, "R10"); rd('h70, 2, "R10");
        // R6 locality
        wr('h08, 2, 64'h1, "R6"); rd('h00, 2, "R6"); rd('h0C, 2, "R6");
        wr('h08, 2, 64'h3, "R6"); rd('h00, 2, "R6"); rd('h0C, 2, "R6");
        wr('h08, 0, 64'h1, "R6"); wr('h08, 2, 64'h2, "R6"); rd('h0C, 0, "R6");
        // R7 idle handshake
        wr('h40, 2, 64'h1, "R7"); rd('h44, 2, "R7"); wr('h40, 2, 64'h3, "R7"); rd('h44, 2, "R7");
        wr('h40, 2, 64'h2, "R7"); rd('h44, 2, "R7"); wr('h40, 2, 64'h0, "R7"); rd('h44, 2, "R7");
        // R11 narrow placement
        wr('h4D, 0, 64'h1, "R11"); rd('h4C, 2, "R11");
        wr('h41, 0, 64'h1, "R11"); rd('h44, 2, "R11");
        wr('h42, 1, 64'h1, "R11"); rd('h44, 2, "R11");
        wr('h40, 0, 64'h1, "R11"); rd('h44, 2, "R11");
        wr('h08, 0, 64'h1, "R11"); wr('h09, 0, 64'h2, "R11"); rd('h00, 2, "R11");
        // R12 cancel
        wr('h48, 2, 64'hFFFF_FFFF, "R12"); rd('h48, 3, "R12");
        // R8 start
        wr('h4C, 2, 64'h0, "R8"); wr('h4C, 0, 64'h1, "R8"); rd('h4C, 2, "R8");
        wr('h4C, 2, 64'h1, "R8"); cyc(0, 0, 0, 0, '0, 0, "R8");
        // R9 done
        cyc(0, 0, 0, 0, '0, 1, "R9"); rd('h4C, 2, "R9");
        cyc(1, 1, 'h4C, 2, 64'h1, 1, "R9"); rd('h4C, 2, "R9");
        wr('h4C, 2, 64'h1, "R8"); cyc(1, 1, 'h4C, 2, 64'h1, 1, "R9"); wr('h4C, 1, 64'h1, "R8");
        cyc(0, 0, 0, 0, '0, 1, "R9");
        // R10 storage writes
        wr('h58, 2, 64'h40, "R10"); rd('h58, 2, "R10");
        wr('h68, 3, 64'h0123_4567_89AB_CDEF, "R10"); rd('h68, 3, "R10"); rd('h6C, 2, "R10");
        wr('h60, 3, 64'hAAAA_BBBB_CCCC_DDDD, "R10"); rd('h64, 1, "R10");
        // R13 buffer
        wr('h80, 3, 64'hDEAD_BEEF_0BAD_F00D, "R13"); rd('h80, 3, "R13");
        wr('h85, 0, 64'h5A, "R13"); rd('h84, 2, "R13"); rd('h86, 1, "R13");
        wr('hFF8, 3, 64'h1122_3344_5566_7788, "R13"); rd('hFFC, 2, "R13"); rd('hFFF, 0, "R13");
        wr('h102, 1, 64'hBEEF, "R13"); rd('h102, 1, "R13");
        for (int k = 0; k < 60; k++) begin
            int a;
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            a = 'h80 + 8 * int'(lcg[40:32] % 9'd496);
            wr(a, 3, lcg, "R13");
            rd(a + 4 * int'(lcg[20]), 2, "R13");
            rd(a, 3, "R13");
            cyc(0, 0, 0, 0, '0, lcg[7], "R1");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule